// File: doc/BRIEF.md
# Two-Sided Processor Mailbox

This block lets two processors that share one clock exchange messages and signals. Each side, called A and B, has a small register port with a control register, a status register, four transmit words and four receive words. A word that one side places in transmit slot n appears in receive slot n of the opposite side. Per-slot full and empty status lets software hand messages over without losing any.

Besides data words, each side can raise four general interrupt requests toward the other side. A request stays raised until the opposite side acknowledges it. Each side can also push a three-bit flag value across. The delivery of those flags is visible as a pending bit. Each side sees the opposite side's two-bit power state and an event-pending summary. Each side has one interrupt line, which combines its status bits with the matching enables.

Register addresses on each port: 0 control, 1 status, 2 to 5 transmit slots 0 to 3, 6 to 9 receive slots 0 to 3. Writes take effect at the clock edge. Read data is combinational for the addressed register.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, status reads 0x00F00000 on both sides (all transmit-empty bits 23..20 set, every other bit 0 while both power inputs are 0), control reads 0, and both interrupt lines are 0.
- R2: A write to transmit slot n whose empty bit is 1 stores the word. From the next cycle, the writer's empty bit (status bit 23-n) is 0, the far side's receive-full bit (status bit 27-n) is 1, and the far side's receive slot n returns the word.
- R3: A read of receive slot n with the read strobe clears that receive-full bit and sets the sender's transmit-empty bit n again from the next cycle.
- R4: A write to a transmit slot whose empty bit is 0 is ignored: the far side later reads the earlier word.
- R5: Writing 1 to control bit 19-n sets request n (read back at control bit 19-n) and far pending bit n (status bit 31-n) in the next cycle. Request n stays set while it is not accepted. Writing 0 to it, or triggering again, changes nothing.
- R6: Writing status with bit 31-n at 1 clears pending bit n and, at the same edge, the opposite side's request n. Writing 0 there leaves it set.
- R7: Every control write made while no flag update is pending loads control bits 2..0 as the outgoing flags. Flag-update-pending (status bit 3) then reads 1 for exactly one cycle, and the far side's status bits 2..0 take the value the cycle after. A control write during that cycle leaves the flags unchanged.
- R8: Status bits 5..4 report the opposite side's power input (0 run, 1 wait, 2 stop, 3 deep sleep).
- R9: Status bit 6 (event pending) is 1 while this side has a flag update pending or any of its requests set.
- R10: A side's interrupt line is the OR, over n, of pending n AND enable bit 31-n, receive-full n AND enable bit 27-n, and transmit-empty n AND enable bit 23-n. The enables are the control bits at those positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (consumes a receive slot) |
| a_addr | input | 4 | Side A register address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_pm | input | 2 | Side A power state, shown to B |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (consumes a receive slot) |
| b_addr | input | 4 | Side B register address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_pm | input | 2 | Side B power state, shown to A |
| b_irq | output | 1 | Side B interrupt |

## Verification
Every cycle, the assertions check the A-to-B slot handshake: an accepted send fills the slot, a consuming read drains it, and a full slot stays full until it is read. They also check that a request survives until the far side's clear and falls right after it, and that a flag update is pending for no more than one cycle. Only the bench scenarios show the data words carried, the bit positions seen through the status and control reads, the refusal of overwrites, the power-state report and the interrupt combination per group.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    localparam int NUM_CH = 4;
    localparam int DATA_W = 32;
    localparam int FLAG_W = 3;
    localparam int ADDR_W = 4;
    localparam int PM_W   = 2;

    // register map
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_TX0  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_RX0  = ADR_TX0 + ADDR_W'(NUM_CH);

    // bit positions, index 0 at the msb of each group
    localparam int GIP_MSB = 31;
    localparam int RXF_MSB = 27;
    localparam int TXE_MSB = 23;
    localparam int GIR_MSB = 19;
    localparam int FUP_BIT = 3;
    localparam int PM_LSB  = 4;
    localparam int EP_BIT  = 6;

    typedef enum logic [PM_W-1:0] {
        PWR_RUN   = 2'd0,
        PWR_WAIT  = 2'd1,
        PWR_STOP  = 2'd2,
        PWR_DEEP  = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/ipc_lane.sv
// One direction of the mailbox: sender side writes, receiver side consumes.
module ipc_lane
    import ipc_mailbox_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          snd_wr,
    input  logic [DW-1:0]         snd_data,
    input  logic [N-1:0]          snd_trig,
    input  logic                  snd_flag_wr,
    input  logic [FW-1:0]         snd_flag_val,
    input  logic [N-1:0]          rcv_rd,
    input  logic [N-1:0]          rcv_clr,
    output logic [N-1:0][DW-1:0]  words,
    output logic [N-1:0]          full,
    output logic [N-1:0]          req,
    output logic [FW-1:0]         stage,
    output logic                  fup,
    output logic [FW-1:0]         flags
);

    typedef struct packed {
        logic [N-1:0][DW-1:0] data;
        logic [N-1:0]         full;
        logic [N-1:0]         req;
        logic [FW-1:0]        stage;
        logic                 fup;
        logic [FW-1:0]        flags;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // slot handshake: consume drains, accepted send fills
            if (rcv_rd[i]) begin
                st_d.full[i] = 1'b0;
            end
            if (snd_wr[i] && !st_q.full[i]) begin
                st_d.data[i] = snd_data;
                st_d.full[i] = 1'b1;
            end
            // request line: set only when idle, dropped by far acknowledge
            if (st_q.req[i]) begin
                if (rcv_clr[i]) begin
                    st_d.req[i] = 1'b0;
                end
            end else if (snd_trig[i]) begin
                st_d.req[i] = 1'b1;
            end
        end
        // flag transfer: one cycle in flight
        if (st_q.fup) begin
            st_d.flags = st_q.stage;
            st_d.fup   = 1'b0;
        end else if (snd_flag_wr) begin
            st_d.stage = snd_flag_val;
            st_d.fup   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.data;
    assign full  = st_q.full;
    assign req   = st_q.req;
    assign stage = st_q.stage;
    assign fup   = st_q.fup;
    assign flags = st_q.flags;

endmodule

// File: rtl/ipc_port.sv
// Register port of one side: decode, enables, read mux and interrupt.
module ipc_port
    import ipc_mailbox_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic                  irq,
    input  logic [PM_W-1:0]       far_pm,
    // outgoing lane
    input  logic [N-1:0][DW-1:0]  tx_words,
    input  logic [N-1:0]          tx_full,
    input  logic [N-1:0]          tx_req,
    input  logic [FW-1:0]         tx_stage,
    input  logic                  tx_fup,
    output logic [N-1:0]          snd_wr,
    output logic [DW-1:0]         snd_data,
    output logic [N-1:0]          snd_trig,
    output logic                  snd_flag_wr,
    output logic [FW-1:0]         snd_flag_val,
    // incoming lane
    input  logic [N-1:0][DW-1:0]  rx_words,
    input  logic [N-1:0]          rx_full,
    input  logic [N-1:0]          rx_req,
    input  logic [FW-1:0]         rx_flags,
    output logic [N-1:0]          rcv_rd,
    output logic [N-1:0]          rcv_clr
);

    typedef struct packed {
        logic [N-1:0] gie;
        logic [N-1:0] rie;
        logic [N-1:0] tie;
    } en_t;

    en_t en_d, en_q;

    logic          hit_ctrl_w;
    logic          hit_stat_w;
    logic [DW-1:0] ctrl_view;
    logic [DW-1:0] stat_view;
    logic [N-1:0]  tx_empty;

    always_comb begin
        en_d         = en_q;
        hit_ctrl_w   = wr && (addr == ADR_CTRL);
        hit_stat_w   = wr && (addr == ADR_STAT);
        snd_data     = wdata;
        snd_flag_wr  = hit_ctrl_w;
        snd_flag_val = wdata[FW-1:0];
        snd_wr       = '0;
        snd_trig     = '0;
        rcv_rd       = '0;
        rcv_clr      = '0;
        tx_empty     = ~tx_full;
        ctrl_view    = '0;
        stat_view    = '0;
        irq          = 1'b0;

        for (int i = 0; i < N; i++) begin
            snd_wr[i]  = wr && (addr == AW'(ADR_TX0 + AW'(i)));
            rcv_rd[i]  = rd && (addr == AW'(ADR_RX0 + AW'(i)));
            rcv_clr[i] = hit_stat_w && wdata[GIP_MSB - i];
            if (hit_ctrl_w) begin
                en_d.gie[i] = wdata[GIP_MSB - i];
                en_d.rie[i] = wdata[RXF_MSB - i];
                en_d.tie[i] = wdata[TXE_MSB - i];
                snd_trig[i] = wdata[GIR_MSB - i];
            end

            ctrl_view[GIP_MSB - i] = en_q.gie[i];
            ctrl_view[RXF_MSB - i] = en_q.rie[i];
            ctrl_view[TXE_MSB - i] = en_q.tie[i];
            ctrl_view[GIR_MSB - i] = tx_req[i];

            stat_view[GIP_MSB - i] = rx_req[i];
            stat_view[RXF_MSB - i] = rx_full[i];
            stat_view[TXE_MSB - i] = tx_empty[i];

            irq = irq | (rx_req[i] & en_q.gie[i])
                      | (rx_full[i] & en_q.rie[i])
                      | (tx_empty[i] & en_q.tie[i]);
        end

        ctrl_view[FW-1:0]              = tx_stage;
        stat_view[FW-1:0]              = rx_flags;
        stat_view[FUP_BIT]             = tx_fup;
        stat_view[PM_LSB +: PM_W]      = far_pm;
        stat_view[EP_BIT]              = tx_fup | (|tx_req);

        rdata = '0;
        if (addr == ADR_CTRL) begin
            rdata = ctrl_view;
        end else if (addr == ADR_STAT) begin
            rdata = stat_view;
        end
        for (int i = 0; i < N; i++) begin
            if (addr == AW'(ADR_TX0 + AW'(i))) begin
                rdata = tx_words[i];
            end
            if (addr == AW'(ADR_RX0 + AW'(i))) begin
                rdata = rx_words[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_wr,
    input  logic            a_rd,
    input  logic [AW-1:0]   a_addr,
    input  logic [DW-1:0]   a_wdata,
    output logic [DW-1:0]   a_rdata,
    input  logic [PM_W-1:0] a_pm,
    output logic            a_irq,
    input  logic            b_wr,
    input  logic            b_rd,
    input  logic [AW-1:0]   b_addr,
    input  logic [DW-1:0]   b_wdata,
    output logic [DW-1:0]   b_rdata,
    input  logic [PM_W-1:0] b_pm,
    output logic            b_irq
);

    localparam int SIDES = 2;

    // per side (index 0 = A, 1 = B)
    logic [SIDES-1:0]      wr_s, rd_s, irq_s;
    logic [AW-1:0]         addr_s  [SIDES];
    logic [DW-1:0]         wdata_s [SIDES];
    logic [DW-1:0]         rdata_s [SIDES];
    logic [PM_W-1:0]       pm_s    [SIDES];

    // per lane (index = sending side)
    logic [N-1:0][DW-1:0]  lane_words [SIDES];
    logic [N-1:0]          lane_full  [SIDES];
    logic [N-1:0]          lane_req   [SIDES];
    logic [FW-1:0]         lane_stage [SIDES];
    logic [SIDES-1:0]      lane_fup;
    logic [FW-1:0]         lane_flags [SIDES];
    logic [N-1:0]          snd_wr     [SIDES];
    logic [DW-1:0]         snd_data   [SIDES];
    logic [N-1:0]          snd_trig   [SIDES];
    logic [SIDES-1:0]      snd_flag_wr;
    logic [FW-1:0]         snd_flag_val [SIDES];
    // produced by receiving side s, consumed by lane 1-s
    logic [N-1:0]          rcv_rd     [SIDES];
    logic [N-1:0]          rcv_clr    [SIDES];

    assign wr_s       = {b_wr, a_wr};
    assign rd_s       = {b_rd, a_rd};
    assign addr_s[0]  = a_addr;
    assign addr_s[1]  = b_addr;
    assign wdata_s[0] = a_wdata;
    assign wdata_s[1] = b_wdata;
    assign pm_s[0]    = a_pm;
    assign pm_s[1]    = b_pm;
    assign a_rdata    = rdata_s[0];
    assign b_rdata    = rdata_s[1];
    assign a_irq      = irq_s[0];
    assign b_irq      = irq_s[1];

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int FAR = SIDES - 1 - s;

        ipc_lane #(.N(N), .DW(DW), .FW(FW)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .snd_wr       (snd_wr[s]),
            .snd_data     (snd_data[s]),
            .snd_trig     (snd_trig[s]),
            .snd_flag_wr  (snd_flag_wr[s]),
            .snd_flag_val (snd_flag_val[s]),
            .rcv_rd       (rcv_rd[FAR]),
            .rcv_clr      (rcv_clr[FAR]),
            .words        (lane_words[s]),
            .full         (lane_full[s]),
            .req          (lane_req[s]),
            .stage        (lane_stage[s]),
            .fup          (lane_fup[s]),
            .flags        (lane_flags[s])
        );

        ipc_port #(.N(N), .DW(DW), .FW(FW), .AW(AW)) u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr           (wr_s[s]),
            .rd           (rd_s[s]),
            .addr         (addr_s[s]),
            .wdata        (wdata_s[s]),
            .rdata        (rdata_s[s]),
            .irq          (irq_s[s]),
            .far_pm       (pm_s[FAR]),
            .tx_words     (lane_words[s]),
            .tx_full      (lane_full[s]),
            .tx_req       (lane_req[s]),
            .tx_stage     (lane_stage[s]),
            .tx_fup       (lane_fup[s]),
            .snd_wr       (snd_wr[s]),
            .snd_data     (snd_data[s]),
            .snd_trig     (snd_trig[s]),
            .snd_flag_wr  (snd_flag_wr[s]),
            .snd_flag_val (snd_flag_val[s]),
            .rx_words     (lane_words[FAR]),
            .rx_full      (lane_full[FAR]),
            .rx_req       (lane_req[FAR]),
            .rx_flags     (lane_flags[FAR]),
            .rcv_rd       (rcv_rd[s]),
            .rcv_clr      (rcv_clr[s])
        );
    end

endmodule

// File: rtl/ipc_mailbox_chk.sv
// Protocol checker for the A-to-B lane and both flag paths.
module ipc_mailbox_chk
    import ipc_mailbox_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_wr,
    input logic [AW-1:0] a_addr,
    input logic          b_wr,
    input logic          b_rd,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_wdata,
    input logic [N-1:0]  full_ab,
    input logic [N-1:0]  req_ab,
    input logic [1:0]    fup_s
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        localparam logic [AW-1:0] TXA = AW'(ADR_TX0 + AW'(i));
        localparam logic [AW-1:0] RXA = AW'(ADR_RX0 + AW'(i));

        logic send_i, take_i, ack_i;
        assign send_i = a_wr && (a_addr == TXA);
        assign take_i = b_rd && (b_addr == RXA);
        assign ack_i  = b_wr && (b_addr == ADR_STAT) && b_wdata[GIP_MSB - i];

        // R2
        p_send_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (send_i && !full_ab[i]) |=> full_ab[i]);
        // R3
        p_take_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (take_i && !send_i) |=> !full_ab[i]);
        // R4
        p_full_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (full_ab[i] && !take_i) |=> full_ab[i]);
        // R5
        p_req_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ab[i] && !ack_i) |=> req_ab[i]);
        // R6
        p_req_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ab[i] && ack_i) |=> !req_ab[i]);
    end

    for (genvar s = 0; s < 2; s++) begin : g_flag
        // R7
        p_flag_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            fup_s[s] |=> !fup_s[s]);
    end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_wr    (a_wr),
    .a_addr  (a_addr),
    .b_wr    (b_wr),
    .b_rd    (b_rd),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .full_ab (lane_full[0]),
    .req_ab  (lane_req[0]),
    .fup_s   (lane_fup)
);

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [3:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic [1:0]  a_pm = 0, b_pm = 0;
    logic        a_irq, b_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int          side;
        int          kind;   // 0 = read data, 1 = interrupt line
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    bit    mon_req = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_pm(a_pm), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_pm(b_pm), .b_irq(b_irq)
    );

    // expected status word from index-ordered fields
    function automatic logic [31:0] stat(logic [3:0] gip, logic [3:0] rxf, logic [3:0] txe,
                                         logic [2:0] flg, logic fup, logic [1:0] pm, logic ep);
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) begin
            v[31-i] = gip[i];
            v[27-i] = rxf[i];
            v[23-i] = txe[i];
        end
        v[2:0] = flg;
        v[3]   = fup;
        v[5:4] = pm;
        v[6]   = ep;
        return v;
    endfunction

    task automatic idle_bus();
        a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0; mon_req = 0;
    endtask

    // every task occupies exactly one cycle, starting and ending at a falling edge
    task automatic wr(int side, logic [3:0] addr, logic [31:0] data);
        idle_bus();
        if (side == 0) begin a_wr = 1; a_addr = addr; a_wdata = data; end
        else           begin b_wr = 1; b_addr = addr; b_wdata = data; end
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd_chk(int side, logic [3:0] addr, logic [31:0] exp, string tag);
        item_t it;
        idle_bus();
        it.side = side; it.kind = 0; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        if (side == 0) begin a_rd = 1; a_addr = addr; end
        else           begin b_rd = 1; b_addr = addr; end
        mon_req = 1;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic irq_chk(int side, logic exp, string tag);
        item_t it;
        idle_bus();
        it.side = side; it.kind = 1; it.exp = {31'b0, exp}; it.tag = tag;
        sb.push_back(it);
        mon_req = 1;
        @(negedge clk);
        idle_bus();
    endtask

    // monitor: samples mid-cycle and compares against the scoreboard
    always @(negedge clk) begin
        #2;
        if (mon_req) begin
            item_t it;
            logic [31:0] act;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty actual=none expected=item");
            end else begin
                it = sb.pop_front();
                if (it.kind == 0) act = (it.side == 0) ? a_rdata : b_rdata;
                else              act = {31'b0, (it.side == 0) ? a_irq : b_irq};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s side=%0d actual=%h expected=%h", it.tag, it.side, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd_chk(0, 4'd1, 32'h00F0_0000, "R1 status A");
        rd_chk(1, 4'd1, 32'h00F0_0000, "R1 status B");
        rd_chk(0, 4'd0, 32'h0, "R1 ctrl A");
        irq_chk(0, 1'b0, "R1 irq A");
        irq_chk(1, 1'b0, "R1 irq B");

        // R2 / R3 send on slot 1, consume on far side
        wr(0, 4'd3, 32'hDEAD_BEEF);
        rd_chk(1, 4'd1, stat(0, 4'b0010, 4'b1111, 0, 0, 0, 0), "R2 far full");
        rd_chk(0, 4'd1, stat(0, 4'b0000, 4'b1101, 0, 0, 0, 0), "R2 local empty clear");
        rd_chk(1, 4'd7, 32'hDEAD_BEEF, "R2 far word");
        rd_chk(1, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 0), "R3 far drained");
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 0), "R3 sender empty again");

        // B to A direction on slot 3
        wr(1, 4'd5, 32'h0BAD_F00D);
        rd_chk(0, 4'd9, 32'h0BAD_F00D, "R2 reverse word");
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 0), "R3 reverse drained");

        // R4 overwrite of a full slot is refused
        wr(0, 4'd4, 32'h0000_0011);
        wr(0, 4'd4, 32'h0000_0022);
        rd_chk(1, 4'd8, 32'h0000_0011, "R4 first word kept");
        wr(0, 4'd4, 32'h0000_0033);
        rd_chk(1, 4'd8, 32'h0000_0033, "R4 accepted after consume");

        // R8 far power state
        a_pm = 2'd2; b_pm = 2'd3;
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 0, 2'd3, 0), "R8 A sees B deep sleep");
        rd_chk(1, 4'd1, stat(0, 0, 4'b1111, 0, 0, 2'd2, 0), "R8 B sees A stop");
        a_pm = 2'd0; b_pm = 2'd0;

        // R5 / R6 / R9 general request index 0
        wr(0, 4'd0, 32'h0008_0000);
        rd_chk(0, 4'd0, 32'h0008_0000, "R5 request read back");
        rd_chk(1, 4'd1, stat(4'b0001, 0, 4'b1111, 0, 0, 0, 0), "R5 far pending");
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 1), "R9 event pending by request");
        wr(1, 4'd1, 32'h0000_0000);
        rd_chk(1, 4'd1, stat(4'b0001, 0, 4'b1111, 0, 0, 0, 0), "R6 write 0 keeps pending");
        wr(0, 4'd0, 32'h0000_0000);
        wr(0, 4'd0, 32'h0008_0000);
        rd_chk(0, 4'd0, 32'h0008_0000, "R5 retrigger and zero no effect");
        wr(1, 4'd1, 32'h8000_0000);
        rd_chk(1, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 0), "R6 pending cleared");
        rd_chk(0, 4'd0, 32'h0, "R6 request dropped");
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 0), "R9 event pending low");

        // R7 flag transfer
        wr(0, 4'd0, 32'h0000_0005);
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 1, 0, 1), "R7 update pending");
        rd_chk(1, 4'd1, stat(0, 0, 4'b1111, 3'd5, 0, 0, 0), "R7 flags delivered");
        rd_chk(0, 4'd1, stat(0, 0, 4'b1111, 0, 0, 0, 0), "R7 pending cleared");
        wr(0, 4'd0, 32'h0000_0002);
        wr(0, 4'd0, 32'h0000_0007);
        rd_chk(1, 4'd1, stat(0, 0, 4'b1111, 3'd2, 0, 0, 0), "R7 write during pending ignored");
        rd_chk(0, 4'd0, 32'h0000_0002, "R7 staged value kept");

        // R10 interrupt groups
        wr(0, 4'd0, 32'h0080_0000);
        irq_chk(0, 1'b1, "R10 tx empty enable");
        wr(0, 4'd2, 32'h1234_5678);
        irq_chk(0, 1'b0, "R10 tx slot taken");
        wr(1, 4'd0, 32'h0800_0000);
        irq_chk(1, 1'b1, "R10 rx full enable");
        rd_chk(1, 4'd6, 32'h1234_5678, "R10 word");
        irq_chk(1, 1'b0, "R10 rx drained");
        irq_chk(0, 1'b1, "R10 tx empty again");
        wr(1, 4'd0, 32'h8000_0000);
        wr(0, 4'd0, 32'h0008_0000);
        irq_chk(0, 1'b0, "R10 A enables cleared");
        irq_chk(1, 1'b1, "R10 general pending enable");
        wr(1, 4'd1, 32'h8000_0000);
        irq_chk(1, 1'b0, "R10 general cleared");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule